// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Interface

This block lets a local microprocessor read and write a bank of sixteen 16-bit control registers over one of two bus styles. A static strap chooses the style. In the first style the processor gives separate active-low read and write strobes, and the block answers on a ready line. In the second style an active-low data strobe is qualified by a read/write level, and the block answers with a transfer acknowledge. Both styles share the same two strobe pins and one active-low handshake output.

A second static strap sets the data path width. In 16-bit mode each access moves a whole register. In 8-bit mode the lowest address bit picks one byte of a register, and only the low byte lane of the bus is used.

The strobes are asynchronous to the internal clock, so they pass through a two-flop synchronizer. A fixed number of wait cycles then elapses before the handshake completes. The data bus is split into an input, an output and a per-bit output enable, so the bus can be built outside the block. The active-low reset is asynchronous.

Top module: `hbus_regif`

## Requirements
- R1: With `mode_ds_i`=0, `rd_n_i` and `wr_n_i` are separate active-low read and write strobes. With `mode_ds_i`=1, `rd_n_i` is an active-low data strobe and `wr_n_i` is a read/write level, where 1 means read and 0 means write.
- R2: During a read access, `data_oe_o` is nonzero and `data_o` carries the addressed value, which stays stable while it is driven. Three clock cycles after the strobe is released, `data_oe_o` is 0. Write accesses never drive the bus.
- R3: A write access stores `data_i` into the addressed register, and a later read returns the stored value.
- R4: With `mode_ds_i`=0, `hs_o` is a ready line. It is low for exactly WAIT_CYC cycles at the start of each access, then goes high. It stays high until the next access begins.
- R5: With `mode_ds_i`=1, `hs_o` is an acknowledge. It goes low when the access completes and stays low while the data strobe is held. It is high again three cycles after the strobe is released.
- R6: The handshake completes (ready high after its low phase, or acknowledge low) exactly WAIT_CYC+3 clock edges after the strobe is asserted. Two of these edges are for synchronization and one is for decode.
- R7: With `wide_i`=1, an access moves all 16 bits, `addr_i[0]` is ignored, and `data_oe_o`=16'hFFFF on reads.
- R8: With `wide_i`=0, `addr_i[0]`=0 selects bits 7:0 and `addr_i[0]`=1 selects bits 15:8 of the register. A write changes only the selected byte and takes it from `data_i[7:0]`. A read drives `data_o` = {8'h00, byte} with `data_oe_o`=16'h00FF.
- R9: The register index is `addr_i[5:1]`. Indices 16 to 31 are unmapped: reads of them return 0, and writes to them leave every register unchanged.
- R10: While `rst_n` is low, `data_oe_o`=0 and `hs_oe_o`=0, and register i returns to RST_BASE | i (16'hA500 | i by default). `hs_oe_o` is 1 after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ds_i | input | 1 | Bus style strap: 1 = data strobe with read/write level, 0 = separate strobes |
| wide_i | input | 1 | Width strap: 1 = 16-bit bus, 0 = 8-bit bus |
| addr_i | input | 6 | Register index in bits 5:1, byte select in bit 0 |
| rd_n_i | input | 1 | Read strobe, or data strobe, active low |
| wr_n_i | input | 1 | Write strobe (active low), or read/write level |
| data_i | input | 16 | Data bus input |
| data_o | output | 16 | Data bus output value |
| data_oe_o | output | 16 | Per-bit output enable for the data bus |
| hs_o | output | 1 | Active-low ready / acknowledge handshake |
| hs_oe_o | output | 1 | Output enable for the handshake pin |

## Verification
The bench checks the wait length and the completion latency in both bus styles. A wrong counter limit or a missing synchronizer stage shows up as a latency other than WAIT_CYC+3. It checks that the acknowledge holds until the strobe is released. A design that releases the acknowledge early would complete writes that the processor has not finished. In 8-bit mode it writes one byte and then reads the whole word back. Lane-steering errors then show up as a corrupted neighbour byte or driven upper lanes. Writes to unmapped indices are followed by reads of the alias index 16 lower, which exposes a decoder that drops the top index bit.

// File: rtl/hbus_pkg.sv
// Shared types for the host bus register interface.
// Assumes a fixed 16-bit register word.
package hbus_pkg;

    localparam int unsigned HB_WORD_W = 16;

    // Access sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } hbus_state_e;

endpackage

// File: rtl/hbus_sync.sv
// Two-flop synchronizer bank for asynchronous strobe inputs.
// Assumes each bit is an independent level; RST_VAL is the idle level.
module hbus_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one asynchronous bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                stab_q <= RST_VAL;
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end

        assign sync_o[b] = stab_q;
    end

endmodule

// File: rtl/hbus_ctrl.sv
// Access sequencer: decodes synchronized strobes per bus style, counts
// wait cycles, issues the write pulse and drives the shared handshake.
// Assumes addr_i is stable while a strobe is asserted.
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 2,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ds_i,
    input  logic              rd_s_i,
    input  logic              wr_s_i,
    input  logic [ADDR_W-1:0] addr_i,
    output hbus_state_e       state_o,
    output logic              rd_cyc_o,
    output logic              wr_pulse_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic              hs_o,
    output logic              hs_oe_o
);

    localparam int unsigned CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    hbus_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rd_req;
    logic             wr_req;
    logic             any_req;

    // Interpret the shared strobe pins according to the bus style strap
    always_comb begin
        if (mode_ds_i) begin
            rd_req = !rd_s_i && wr_s_i;
            wr_req = !rd_s_i && !wr_s_i;
        end else begin
            rd_req = !rd_s_i;
            wr_req = !wr_s_i;
        end
        any_req = rd_req || wr_req;
    end

    // Sequence one access: idle, wait count, completed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            rd_cyc_o <= 1'b0;
            addr_q_o <= '0;
            hs_oe_o  <= 1'b0;
        end else begin
            hs_oe_o <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (any_req) begin
                        state_q  <= ST_WAIT;
                        cnt_q    <= '0;
                        rd_cyc_o <= rd_req;
                        addr_q_o <= addr_i;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == CNT_LAST) begin
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (!any_req) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Commit a write on the last wait cycle
    always_comb begin
        wr_pulse_o = (state_q == ST_WAIT) && (cnt_q == CNT_LAST) && !rd_cyc_o;
    end

    // Shared handshake: ready low during wait, or acknowledge low when done
    always_comb begin
        if (mode_ds_i) begin
            hs_o = (state_q != ST_DONE);
        end else begin
            hs_o = (state_q != ST_WAIT);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/hbus_regbank.sv
// Register bank with byte-lane steering for 8-bit and 16-bit bus widths.
// Assumes addr_i[ADDR_W-1:1] is the register index and addr_i[0] the
// byte select; indices at or above NUM_REGS are unmapped.
module hbus_regbank
    import hbus_pkg::*;
#(
    parameter int unsigned          NUM_REGS = 16,
    parameter int unsigned          ADDR_W   = 6,
    parameter logic [HB_WORD_W-1:0] RST_BASE = 16'hA500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wide_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [HB_WORD_W-1:0] wdata_i,
    output logic [HB_WORD_W-1:0] rdata_o
);

    localparam int unsigned IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0]              idx;
    logic                          bsel;
    logic [NUM_REGS*HB_WORD_W-1:0] regs_flat;
    logic [HB_WORD_W-1:0]          word;

    assign idx  = addr_i[ADDR_W-1:1];
    assign bsel = addr_i[0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [HB_WORD_W-1:0] word_q;

        // Hold one register; update the full word or one byte lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= RST_BASE | HB_WORD_W'(g);
            end else if (wr_en_i && (idx == IDX_W'(g))) begin
                if (wide_i) begin
                    word_q <= wdata_i;
                end else if (bsel) begin
                    word_q[15:8] <= wdata_i[7:0];
                end else begin
                    word_q[7:0] <= wdata_i[7:0];
                end
            end
        end

        assign regs_flat[g*HB_WORD_W +: HB_WORD_W] = word_q;
    end

    // Select the addressed word; unmapped indices read as zero
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                word = regs_flat[i*HB_WORD_W +: HB_WORD_W];
            end
        end
    end

    // Steer the word onto the low lane in 8-bit mode
    always_comb begin
        if (wide_i) begin
            rdata_o = word;
        end else begin
            rdata_o = {8'h00, (bsel ? word[15:8] : word[7:0])};
        end
    end

endmodule

// File: rtl/hbus_regif.sv
// Top level: dual-style microprocessor bus slave in front of a register bank.
// Assumes both straps are static while an access is in progress and that
// the external pad logic uses data_oe_o / hs_oe_o as tri-state enables.
module hbus_regif
    import hbus_pkg::*;
#(
    parameter int unsigned          NUM_REGS = 16,
    parameter int unsigned          ADDR_W   = 6,
    parameter int unsigned          WAIT_CYC = 2,
    parameter logic [HB_WORD_W-1:0] RST_BASE = 16'hA500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_ds_i,
    input  logic                 wide_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 rd_n_i,
    input  logic                 wr_n_i,
    input  logic [HB_WORD_W-1:0] data_i,
    output logic [HB_WORD_W-1:0] data_o,
    output logic [HB_WORD_W-1:0] data_oe_o,
    output logic                 hs_o,
    output logic                 hs_oe_o
);

    localparam logic [HB_WORD_W-1:0] OE_WIDE   = '1;
    localparam logic [HB_WORD_W-1:0] OE_NARROW = 16'h00FF;

    logic [1:0]           strobe_s;
    hbus_state_e          state;
    logic                 rd_cyc;
    logic                 wr_pulse;
    logic [ADDR_W-1:0]    addr_q;
    logic [HB_WORD_W-1:0] rdata;
    logic                 read_phase;

    hbus_sync #(
        .WIDTH   (2),
        .RST_VAL (1'b1)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({wr_n_i, rd_n_i}),
        .sync_o  (strobe_s)
    );

    hbus_ctrl #(
        .WAIT_CYC (WAIT_CYC),
        .ADDR_W   (ADDR_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_ds_i  (mode_ds_i),
        .rd_s_i     (strobe_s[0]),
        .wr_s_i     (strobe_s[1]),
        .addr_i     (addr_i),
        .state_o    (state),
        .rd_cyc_o   (rd_cyc),
        .wr_pulse_o (wr_pulse),
        .addr_q_o   (addr_q),
        .hs_o       (hs_o),
        .hs_oe_o    (hs_oe_o)
    );

    hbus_regbank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .RST_BASE (RST_BASE)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide_i  (wide_i),
        .wr_en_i (wr_pulse),
        .addr_i  (addr_q),
        .wdata_i (data_i),
        .rdata_o (rdata)
    );

    // Drive the bus only while a read access is in progress
    always_comb begin
        read_phase = rd_cyc && (state != ST_IDLE);
        data_o     = read_phase ? rdata : '0;
        data_oe_o  = read_phase ? (wide_i ? OE_WIDE : OE_NARROW) : '0;
    end

endmodule

// File: rtl/hbus_regif_chk.sv
// Property checker for hbus_regif, attached by bind.
// Assumes the straps change only while no access is in progress.
module hbus_regif_chk #(
    parameter int unsigned WAIT_CYC = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_ds_i,
    input logic        wide_i,
    input logic        rd_n_i,
    input logic [15:0] data_o,
    input logic [15:0] data_oe_o,
    input logic        hs_o,
    input logic        hs_oe_o
);

    logic [15:0] low_cnt_q;

    // Count consecutive low ready cycles in separate-strobe style
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!mode_ds_i && !hs_o) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end else begin
            low_cnt_q <= '0;
        end
    end

    // R10: outputs released during reset
    always_comb begin
        if (rst_n == 1'b0) begin
            p_reset_tristate_r10: assert (data_oe_o == '0 && hs_oe_o == 1'b0);
        end
    end

    p_ready_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ds_i && !hs_o) |-> (low_cnt_q < 16'(WAIT_CYC)));

    p_ready_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ds_i && hs_o && low_cnt_q != '0) |-> (low_cnt_q == 16'(WAIT_CYC)));

    p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ds_i && $past(rd_n_i, 1) && $past(rd_n_i, 2) && $past(rd_n_i, 3)) |-> hs_o);

    p_lane_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o != '0) |-> (data_oe_o == (wide_i ? 16'hFFFF : 16'h00FF)));

    p_stable_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_oe_o != '0) && $past(data_oe_o != '0)) |-> $stable(data_o));

    p_handshake_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hs_oe_o);

endmodule

bind hbus_regif hbus_regif_chk #(.WAIT_CYC(WAIT_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_ds_i (mode_ds_i),
    .wide_i    (wide_i),
    .rd_n_i    (rd_n_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .hs_o      (hs_o),
    .hs_oe_o   (hs_oe_o)
);

// File: tb/hbus_regif_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random accesses,
// compared against a bench-side register model.
module hbus_regif_tb_top;

    localparam int unsigned WAIT_CYC = 2;
    localparam int unsigned NREG     = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_ds;
    logic        wide;
    logic [5:0]  addr;
    logic        rd_n;
    logic        wr_n;
    logic [15:0] wdata;
    logic [15:0] data_o;
    logic [15:0] data_oe;
    logic        hs;
    logic        hs_oe;

    int checks = 0;
    int errors = 0;
    logic [15:0] mdl [NREG];

    always #4 clk = ~clk;

    hbus_regif #(.WAIT_CYC(WAIT_CYC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_ds_i (mode_ds),
        .wide_i    (wide),
        .addr_i    (addr),
        .rd_n_i    (rd_n),
        .wr_n_i    (wr_n),
        .data_i    (wdata),
        .data_o    (data_o),
        .data_oe_o (data_oe),
        .hs_o      (hs),
        .hs_oe_o   (hs_oe)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [5:0] a, input bit w);
        logic [15:0] word;
        word = (a[5:1] < 5'(NREG)) ? mdl[a[4:1]] : 16'h0000;
        if (w) return word;
        return {8'h00, (a[0] ? word[15:8] : word[7:0])};
    endfunction

    task automatic model_write(input logic [5:0] a, input bit w, input logic [15:0] d);
        if (a[5:1] < 5'(NREG)) begin
            if (w) mdl[a[4:1]] = d;
            else if (a[0]) mdl[a[4:1]][15:8] = d[7:0];
            else mdl[a[4:1]][7:0] = d[7:0];
        end
    endtask

    // One bus access with handshake, latency, data and release checks
    task automatic access(input bit ds, input bit w, input logic [5:0] a,
                          input bit is_wr, input logic [15:0] d);
        int n;
        bit seen_low;
        bit done;
        logic [15:0] exp;
        @(negedge clk);
        mode_ds = ds; wide = w; addr = a; wdata = d;
        if (ds) begin
            rd_n = 1'b0; wr_n = !is_wr;
        end else begin
            rd_n = is_wr; wr_n = !is_wr;
        end
        n = 0; seen_low = 0; done = 0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
            if (ds) done = (hs == 1'b0);
            else begin
                if (!hs) seen_low = 1;
                else if (seen_low) done = 1;
            end
        end
        // R6: completion latency
        check(n == WAIT_CYC + 3, "R6 latency", 16'(n), 16'(WAIT_CYC + 3));
        exp = exp_read(a, w);
        if (!is_wr) begin
            // R2 R7 R8 R9: read data and lane enables
            check(data_o == exp, ds ? "R1 R2 read data (ds)" : "R2 read data", data_o, exp);
            check(data_oe == (w ? 16'hFFFF : 16'h00FF), "R8 lane enable", data_oe,
                  w ? 16'hFFFF : 16'h00FF);
        end else begin
            check(data_oe == 16'h0000, "R2 no drive on write", data_oe, 16'h0000);
            model_write(a, w, d);
        end
        @(negedge clk);
        if (ds) check(hs == 1'b0, "R5 ack held", 16'(hs), 16'h0000);
        else check(hs == 1'b1, "R4 ready high", 16'(hs), 16'h0001);
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (ds) check(hs == 1'b0, "R5 ack until release seen", 16'(hs), 16'h0000);
        @(negedge clk);
        check(hs == 1'b1, ds ? "R5 ack released" : "R4 ready idle high", 16'(hs), 16'h0001);
        check(data_oe == 16'h0000, "R2 bus released", data_oe, 16'h0000);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; mode_ds = 1'b0; wide = 1'b1; addr = '0;
        rd_n = 1'b1; wr_n = 1'b1; wdata = '0;
        for (int i = 0; i < NREG; i++) mdl[i] = 16'hA500 | 16'(i);
        repeat (3) @(negedge clk);
        // R10: reset state
        check(data_oe == 16'h0000, "R10 bus off in reset", data_oe, 16'h0000);
        check(hs_oe == 1'b0, "R10 handshake off in reset", 16'(hs_oe), 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check(hs_oe == 1'b1, "R10 handshake enabled", 16'(hs_oe), 16'h0001);
        check(hs == 1'b1, "R4 idle ready", 16'(hs), 16'h0001);

        // R10: default values of every register
        for (int i = 0; i < NREG; i++) access(1'b0, 1'b1, {5'(i), 1'b0}, 1'b0, 16'h0);

        // R3 R7: full word write, read back with addr[0] set (ignored)
        access(1'b0, 1'b1, {5'd3, 1'b0}, 1'b1, 16'h1234);
        access(1'b0, 1'b1, {5'd3, 1'b1}, 1'b0, 16'h0);

        // R8: byte writes in 8-bit mode, checked as full words
        access(1'b0, 1'b0, {5'd5, 1'b1}, 1'b1, 16'h77BE);
        access(1'b0, 1'b1, {5'd5, 1'b0}, 1'b0, 16'h0);
        access(1'b0, 1'b0, {5'd6, 1'b0}, 1'b1, 16'hFF3C);
        access(1'b0, 1'b1, {5'd6, 1'b0}, 1'b0, 16'h0);
        access(1'b0, 1'b0, {5'd5, 1'b1}, 1'b0, 16'h0);

        // R9: unmapped write ignored, alias index untouched
        access(1'b0, 1'b1, {5'd20, 1'b0}, 1'b1, 16'hDEAD);
        access(1'b0, 1'b1, {5'd20, 1'b0}, 1'b0, 16'h0);
        access(1'b0, 1'b1, {5'd4, 1'b0}, 1'b0, 16'h0);
        access(1'b1, 1'b1, {5'd31, 1'b0}, 1'b1, 16'hBEEF);
        access(1'b1, 1'b1, {5'd15, 1'b0}, 1'b0, 16'h0);

        // R1 R5: data-strobe style write then read
        access(1'b1, 1'b1, {5'd9, 1'b0}, 1'b1, 16'hC0DE);
        access(1'b1, 1'b1, {5'd9, 1'b0}, 1'b0, 16'h0);
        access(1'b1, 1'b0, {5'd9, 1'b1}, 1'b0, 16'h0);

        // Random mix of both styles and widths
        for (int k = 0; k < 150; k++) begin
            logic [5:0] ra;
            ra = {5'($urandom_range(0, 19)), 1'($urandom)};
            access(1'($urandom), 1'($urandom), ra, 1'($urandom), 16'($urandom));
        end

        finish_run();
    end

endmodule